// File: doc/BRIEF.md
# ARINC Receive Label and SDI Filter

This block sits between the serial bit decoder of an ARINC 429 receiver and its receive FIFO. Each time the decoder signals that a complete 32-bit word has been assembled, the filter decides within one clock whether that word is written into the FIFO. Two independent checks can be switched on. The first compares the word's label (received bits 1 to 8) against a table of 16 programmable labels. The second compares received bits 9 and 10, the source/destination identifier, against two configured bit values. A word that fails an enabled check is dropped and leaves no trace at the outputs.

The label table is owned by the filter. The host programs it and reads it back through a sequenced strobe interface. When the label-mode control bit rises, the write and read indices both restart at entry 0. The next 16 write strobes fill entries 0 to 15 in order, and the next 16 read strobes return entries 0 to 15 in order. While label mode is active, word reception is suspended. Received traffic never alters the table.

Top module: `arinc_label_filter`

## Requirements
- R1: After reset `fifo_load` is 0, `host_rdata` is 0x00, and every label entry reads back as 0x00.
- R2: With both checks disabled and label mode off, every `word_done` pulse gives `fifo_load`=1 on the next cycle, with `fifo_word` equal to the `word_in` of the strobe cycle. Without a strobe, `fifo_load` is 0.
- R3: With label recognition enabled, a word is loaded only if `word_in[7:0]` (received bits 1 to 8, with bit 1 at index 0) equals one of the 16 stored entries. An entry holding 0x00 matches a label of 0x00 like any other value.
- R4: With SDI decoding enabled, a word is loaded only if `word_in[8]` (received bit 9) equals `cfg_sdi_b9` and `word_in[9]` (received bit 10) equals `cfg_sdi_b10`.
- R5: With both checks enabled, a word is loaded only when both pass. A rejected word leaves `fifo_load` at 0.
- R6: A 0-to-1 change of `cfg_lbl_mode` resets the write and read indices to entry 0. Starting one cycle later, each `host_wr` strobe stores `host_wdata` into the next entry, from 0 up to 15.
- R7: Write strobes after the 16th in one label-mode session are ignored, and so are write strobes while `cfg_lbl_mode` is 0.
- R8: In label mode, each of the first 16 `host_rd` strobes places the next entry (0 to 15) on `host_rdata` one cycle later. Further read strobes return 0x00. `host_rdata` changes only after a read strobe.
- R9: While `cfg_lbl_mode` is 1, `word_done` never produces `fifo_load`, whatever the check settings are.
- R10: Received words never modify the label table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| word_in | input | 32 | Assembled received word; index n-1 holds ARINC bit n |
| word_done | input | 1 | End-of-word strobe from the bit decoder |
| cfg_lbl_en | input | 1 | Enable label recognition |
| cfg_sdi_en | input | 1 | Enable bits 9/10 compare |
| cfg_sdi_b9 | input | 1 | Expected value of received bit 9 |
| cfg_sdi_b10 | input | 1 | Expected value of received bit 10 |
| cfg_lbl_mode | input | 1 | Label table access mode; suspends reception |
| host_wr | input | 1 | Label write strobe |
| host_wdata | input | 8 | Label value to store |
| host_rd | input | 1 | Label read strobe |
| host_rdata | output | 8 | Label value returned by the last read strobe |
| fifo_load | output | 1 | Write strobe toward the receive FIFO |
| fifo_word | output | 32 | Word presented with the FIFO write strobe |

## Verification
The embedded properties check on every cycle that a load always follows an end-of-word strobe outside label mode, that a loaded word carries the programmed bits 9/10 whenever that check is on, that the open filter passes every word unchanged, that the indices restart on a mode rise and never pass 16, and that the read data moves only after a read strobe. Whether a word is loaded for the right label needs the table contents. So only the bench's sweep can show it: it runs every label value, every bits-9/10 pattern and every enable and expected-bit setting against a table that contains 0x00. Ordered readback, ignored surplus writes and a table untouched by traffic are likewise shown only by the bench's write and read sequences.

// File: rtl/arinc_label_filter.sv
module arinc_label_filter #(
  parameter int N_LBL   = 16,
  parameter int LBL_W   = 8,
  parameter int WORD_W  = 32,
  parameter int SDI_POS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_done,
  input  logic              cfg_lbl_en,
  input  logic              cfg_sdi_en,
  input  logic              cfg_sdi_b9,
  input  logic              cfg_sdi_b10,
  input  logic              cfg_lbl_mode,
  input  logic              host_wr,
  input  logic [LBL_W-1:0]  host_wdata,
  input  logic              host_rd,
  output logic [LBL_W-1:0]  host_rdata,
  output logic              fifo_load,
  output logic [WORD_W-1:0] fifo_word
);
  localparam int IDX_W = $clog2(N_LBL);
  localparam int CNT_W = $clog2(N_LBL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N_LBL);

  logic [LBL_W-1:0] lbl_mem [N_LBL];
  logic [N_LBL-1:0] hit;
  logic             mode_q;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;

  wire mode_rise = cfg_lbl_mode & ~mode_q;
  wire sess      = cfg_lbl_mode & mode_q;
  wire wr_take   = sess & host_wr & (wr_cnt < CNT_MAX);
  wire rd_take   = sess & host_rd & (rd_cnt < CNT_MAX);

  for (genvar i = 0; i < N_LBL; i++) begin : g_lbl
    assign hit[i] = (lbl_mem[i] == word_in[LBL_W-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lbl_mem[i] <= '0;
      else if (wr_take && wr_cnt[IDX_W-1:0] == IDX_W'(i)) lbl_mem[i] <= host_wdata;
    end
  end

  wire lbl_ok = ~cfg_lbl_en | (|hit);
  wire sdi_ok = ~cfg_sdi_en | ((word_in[SDI_POS] == cfg_sdi_b9) & (word_in[SDI_POS+1] == cfg_sdi_b10));
  wire accept = word_done & ~cfg_lbl_mode & lbl_ok & sdi_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      wr_cnt     <= '0;
      rd_cnt     <= '0;
      host_rdata <= '0;
      fifo_load  <= 1'b0;
      fifo_word  <= '0;
    end else begin
      mode_q    <= cfg_lbl_mode;
      fifo_load <= accept;
      if (accept) fifo_word <= word_in;
      if (mode_rise) begin
        wr_cnt <= '0;
        rd_cnt <= '0;
      end else begin
        if (wr_take) wr_cnt <= wr_cnt + 1'b1;
        if (rd_take) rd_cnt <= rd_cnt + 1'b1;
      end
      if (rd_take)      host_rdata <= lbl_mem[rd_cnt[IDX_W-1:0]];
      else if (host_rd) host_rdata <= '0;
    end
  end

  a_r2_load_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_load |-> $past(word_done));
  a_r9_no_load_in_label_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_load |-> !$past(cfg_lbl_mode));
  a_r4_sdi_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_load && $past(cfg_sdi_en)) |->
      (fifo_word[SDI_POS] == $past(cfg_sdi_b9) && fifo_word[SDI_POS+1] == $past(cfg_sdi_b10)));
  a_r2_open_filter_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cfg_lbl_mode && !cfg_lbl_en && !cfg_sdi_en) |=>
      (fifo_load && fifo_word == $past(word_in)));
  a_r7_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt <= CNT_MAX) && (rd_cnt <= CNT_MAX));
  a_r6_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lbl_mode && !mode_q) |=> (wr_cnt == '0 && rd_cnt == '0));
  a_r8_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_rd) |-> $stable(host_rdata));
endmodule

// File: tb/test_arinc_label_filter.sv
module test_arinc_label_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word_in = '0;
  logic        word_done = 1'b0;
  logic        cfg_lbl_en = 1'b0, cfg_sdi_en = 1'b0, cfg_sdi_b9 = 1'b0, cfg_sdi_b10 = 1'b0;
  logic        cfg_lbl_mode = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        fifo_load;
  logic [31:0] fifo_word;

  int total = 0;
  int bad = 0;
  logic [7:0] tbl [16];

  always #2 clk = ~clk;

  arinc_label_filter i_arinc_label_filter (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_done(word_done),
    .cfg_lbl_en(cfg_lbl_en), .cfg_sdi_en(cfg_sdi_en), .cfg_sdi_b9(cfg_sdi_b9),
    .cfg_sdi_b10(cfg_sdi_b10), .cfg_lbl_mode(cfg_lbl_mode), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .fifo_load(fifo_load), .fifo_word(fifo_word));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk) cfg_lbl_mode = m;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk) begin host_wr = 1'b1; host_wdata = v; end
    @(negedge clk) host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] v);
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic send(input logic [31:0] w, input logic exp_load, input string req);
    @(negedge clk) begin word_in = w; word_done = 1'b1; end
    @(negedge clk) word_done = 1'b0;
    chk(req, {31'b0, fifo_load}, {31'b0, exp_load});
    if (exp_load) chk(req, fifo_word, w);
  endtask

  function automatic logic in_tbl(input logic [7:0] l);
    for (int i = 0; i < 16; i++) if (tbl[i] == l) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    for (int i = 0; i < 16; i++) tbl[i] = (i == 7) ? 8'h00 : 8'((i * 37 + 5) % 256);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 load", {31'b0, fifo_load}, 32'd0);
    chk("R1 rdata", {24'b0, host_rdata}, 32'd0);
    // R7 writes ignored outside label mode
    host_write(8'hAA);
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) begin
      host_read(rv);
      chk("R1 entry reset", {24'b0, rv}, 32'd0);
    end
    set_mode(1'b0);
    // R6 program table, R7 extra writes ignored
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) host_write(tbl[i]);
    host_write(8'h5A);
    host_write(8'hC3);
    // R9 reception suspended in label mode
    send(32'h0000_0105, 1'b0, "R9");
    send(32'h0000_0000, 1'b0, "R9");
    // R8 ordered readback, surplus read returns 0
    for (int i = 0; i < 16; i++) begin
      host_read(rv);
      chk("R8 readback", {24'b0, rv}, {24'b0, tbl[i]});
    end
    host_read(rv);
    chk("R8 surplus read", {24'b0, rv}, 32'd0);
    set_mode(1'b0);
    // R2 open filter and idle
    send(32'hDEAD_BEEF, 1'b1, "R2");
    @(negedge clk);
    chk("R2 idle", {31'b0, fifo_load}, 32'd0);
    // R3 R4 R5 sweep
    for (int cfg = 0; cfg < 4; cfg++)
      for (int sd = 0; sd < 4; sd++)
        for (int lab = 0; lab < 256; lab++)
          for (int hi = 0; hi < 4; hi++) begin
            logic [31:0] w;
            logic le, se, e;
            le = cfg[0]; se = cfg[1];
            @(negedge clk) begin
              cfg_lbl_en = le; cfg_sdi_en = se;
              cfg_sdi_b9 = sd[0]; cfg_sdi_b10 = sd[1];
            end
            w = {22'(lab * 977 + hi * 13 + cfg * 5 + sd), 2'(hi), 8'(lab)};
            e = (!le || in_tbl(8'(lab))) && (!se || (hi[0] == sd[0] && hi[1] == sd[1]));
            send(w, e, (le && se) ? "R5" : (le ? "R3" : (se ? "R4" : "R2")));
          end
    // R10 table untouched by traffic, R7 post-session write ignored
    @(negedge clk) begin cfg_lbl_en = 1'b0; cfg_sdi_en = 1'b0; end
    host_write(8'h77);
    set_mode(1'b1);
    for (int i = 0; i < 16; i++) begin
      host_read(rv);
      chk("R10 table intact", {24'b0, rv}, {24'b0, tbl[i]});
    end
    set_mode(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule